// File: doc/BRIEF.md
# Receive Character Queue with DMA Request Generation

This block buffers received serial characters for a host processor and produces an active-low DMA request that tells a DMA controller when characters are waiting. With queueing enabled it holds up to 64 characters in first-in first-out order. With queueing disabled it acts as a single-character holding register.

The request line follows one of two disciplines:
- **Single-transfer discipline.** The line is asserted whenever any character is waiting.
- **Burst discipline.** The line is asserted only when the fill level reaches a selectable threshold, or when characters have sat idle for four character times. Once asserted, it stays asserted until the queue has drained completely.

The burst discipline exists only in queueing mode. Character deserialization, baud timing and line error tracking are handled outside this block.

Top module: `rx_dma_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty. After reset, `level` is 0, `rd_data` is 0, `overrun` is 0, and `rxrdy_n` is 1.
- R2: With `fifo_en`=1 the queue stores up to 64 characters and returns them in arrival order. A read strobe on a non-empty queue places the oldest character on `rd_data` one cycle later. `level` always shows the stored count. A read and a write in the same cycle are both honoured, even when the queue is full.
- R3: With `fifo_en`=0 the capacity is one character (holding-register mode).
- R4: A write strobe that finds no free space is discarded and sets `overrun`. `overrun` stays at 1 until reset.
- R5: A read strobe on an empty queue leaves `rd_data` and `level` unchanged.
- R6: `trig_hit` is 1 when `fifo_en`=1 and `level` is at least the threshold chosen by `trig_sel`. The thresholds are 0→1, 1→16, 2→32 and 3→56. `trig_hit` is always 0 when `fifo_en`=0.
- R7: `timeout` is 1 when `fifo_en`=1, the queue is non-empty, and four `char_tick` pulses have arrived since the last accepted write or read. Any accepted write or read restarts the count, and so does an empty queue.
- R8: Single-transfer discipline applies when `fifo_en`=0, or when `fifo_en`=1 and `dma_mode`=0. Under it, `rxrdy_n` is 0 exactly when `level` is non-zero.
- R9: Burst discipline applies when `fifo_en`=1 and `dma_mode`=1. Under it, `rxrdy_n` falls when `trig_hit` or `timeout` is 1. It then stays at 0 until `level` reaches 0, at which point it returns to 1.
- R10: While `fifo_en`=0, `dma_mode`=1 has no effect: `rxrdy_n` follows R8.
- R11: In a cycle where `fifo_en` differs from its value in the previous cycle, the queue is emptied. In that cycle, write and read strobes are ignored, the idle count is cleared, and the burst latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Received-character strobe |
| wr_data | input | 8 | Received character |
| rd_en | input | 1 | Host read strobe |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| dma_mode | input | 1 | 1 = burst discipline (only when `fifo_en`=1) |
| trig_sel | input | 2 | Threshold select: 1, 16, 32, 56 |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Last character read |
| level | output | 7 | Stored character count |
| trig_hit | output | 1 | Threshold reached |
| timeout | output | 1 | Idle timeout reached |
| overrun | output | 1 | Sticky: a write was dropped |
| rxrdy_n | output | 1 | Active-low DMA request |

## Verification
The in-line assertions check the following on every cycle:
- the stored count never exceeds the capacity of the active mode;
- an empty-queue read leaves the data output untouched;
- `overrun` never clears;
- an accepted write or read always removes the timeout in the following cycle;
- an asserted request in burst discipline releases only when the queue is empty.

Only the bench's scenarios can show the following:
- arrival order across pointer wrap-around;
- each of the four thresholds;
- the exact cycle at which the fourth idle tick raises the request;
- that `dma_mode` is ignored in holding-register mode;
- the flush on a mode change.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        DREQ_SINGLE = 1'b0,
        DREQ_BURST  = 1'b1
    } dreq_mode_e;

    typedef struct packed {
        logic trig;
        logic idle;
    } rxq_event_t;

    // Threshold for a select code, scaled from the queue depth.
    function automatic int unsigned trig_level(int unsigned depth, logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return (depth > 8) ? depth - 8 : depth;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic          drop
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_fire = rd_req && (count != '0) && !flush;
        wr_fire = wr_req && !flush && ((count < cap) || rd_fire);
        drop    = wr_req && !flush && !wr_fire;
    end

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_fire) wptr <= bump(wptr);
            if (rd_fire) begin
                rptr    <= bump(rptr);
                rd_data <= mem[rptr];
            end
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: count never exceeds the storage depth
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R5: an empty read leaves the data output untouched
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && count == '0) |=> $stable(rd_data));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TO_CHARS = 4,
    localparam int TW      = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    input  logic nonempty,
    input  logic char_tick,
    output logic timeout
);

    logic [TW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idle_cnt <= '0;
        end else if (char_tick && idle_cnt != TW'(TO_CHARS)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign timeout = enable && nonempty && (idle_cnt == TW'(TO_CHARS));

    // R7: activity always removes the timeout in the next cycle
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !timeout);

endmodule

// File: rtl/rxq_dreq.sv
module rxq_dreq
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  dreq_mode_e mode,
    input  logic       nonempty,
    input  rxq_event_t ev,
    output logic       rxrdy_n
);

    logic armed;
    logic burst_act;

    assign burst_act = nonempty && (armed || ev.trig || ev.idle);

    always_ff @(posedge clk) begin
        if (rst || flush || mode != DREQ_BURST) armed <= 1'b0;
        else                                    armed <= burst_act;
    end

    always_comb begin
        if (mode == DREQ_BURST) rxrdy_n = !burst_act;
        else                    rxrdy_n = !nonempty;
    end

    // R8: the request is never active on an empty queue
    assert_req_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
        !rxrdy_n |-> nonempty);

    // R9: in burst discipline an active request releases only on drain
    assert_hold_until_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == DREQ_BURST && !rxrdy_n && !flush)
            |=> (!rxrdy_n || !nonempty || mode != DREQ_BURST));

endmodule

// File: rtl/rx_dma_fifo.sv
module rx_dma_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int DW       = 8,
    parameter int TO_CHARS = 4,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    trig_sel,
    input  logic          char_tick,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic          trig_hit,
    output logic          timeout,
    output logic          overrun,
    output logic          rxrdy_n
);

    logic          fen_q;
    logic          flush;
    logic [CW-1:0] cap;
    logic          wr_fire, rd_fire, drop;
    logic          nonempty;
    dreq_mode_e    mode;
    rxq_event_t    ev;

    always_ff @(posedge clk) begin
        if (rst) fen_q <= fifo_en;
        else     fen_q <= fifo_en;
    end

    assign flush    = (fifo_en != fen_q);
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    assign nonempty = (level != '0);
    assign mode     = (fifo_en && dma_mode) ? DREQ_BURST : DREQ_SINGLE;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .cap     (cap),
        .wr_req  (wr_en),
        .wr_data (wr_data),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .count   (level),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire),
        .drop    (drop)
    );

    assign trig_hit = fifo_en && (level >= CW'(trig_level(DEPTH, trig_sel)));

    rxq_timer #(.TO_CHARS(TO_CHARS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .enable    (fifo_en),
        .restart   (wr_fire || rd_fire || flush || !nonempty),
        .nonempty  (nonempty),
        .char_tick (char_tick),
        .timeout   (timeout)
    );

    assign ev.trig = trig_hit;
    assign ev.idle = timeout;

    rxq_dreq u_dreq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .mode     (mode),
        .nonempty (nonempty),
        .ev       (ev),
        .rxrdy_n  (rxrdy_n)
    );

    always_ff @(posedge clk) begin
        if (rst)       overrun <= 1'b0;
        else if (drop) overrun <= 1'b1;
    end

    // R4: the overrun flag is sticky
    assert_sticky_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R3: holding-register mode never stores more than one character
    assert_hold_cap_R3: assert property (@(posedge clk) disable iff (rst)
        !fen_q |-> level <= CW'(1));

endmodule

// File: tb/sim_rx_dma_fifo.sv
module sim_rx_dma_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, rd_en = 0, fifo_en = 1, dma_mode = 0, char_tick = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] trig_sel = 0;
    logic [7:0] rd_data;
    logic [6:0] level;
    logic       trig_hit, timeout, overrun, rxrdy_n;

    always #10 clk = ~clk;

    rx_dma_fifo u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
        .char_tick(char_tick), .rd_data(rd_data), .level(level),
        .trig_hit(trig_hit), .timeout(timeout), .overrun(overrun),
        .rxrdy_n(rxrdy_n)
    );

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // Behavioural model state
    byte unsigned q[$];
    byte unsigned m_last = 0;
    bit m_ovr = 0, m_arm = 0, m_fen = 1;
    int m_idle = 0;

    function automatic int thr(logic [1:0] s);
        case (s) 0: return 1; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    function automatic bit e_trig();
        return fifo_en && q.size() >= thr(trig_sel);
    endfunction
    function automatic bit e_to();
        return fifo_en && q.size() > 0 && m_idle == 4;
    endfunction
    function automatic bit e_rdy_n();
        if (fifo_en && dma_mode) return !(q.size() > 0 && (m_arm || e_trig() || e_to()));
        return q.size() == 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_update();
        bit mode1, act, do_rd, do_wr;
        int cap;
        if (rst) begin
            q.delete(); m_last = 0; m_ovr = 0; m_arm = 0; m_idle = 0; m_fen = fifo_en;
            return;
        end
        if (fifo_en != m_fen) begin
            q.delete(); m_idle = 0; m_arm = 0; m_fen = fifo_en;
            return;
        end
        mode1 = fifo_en && dma_mode;
        act   = q.size() > 0 && (m_arm || e_trig() || e_to());
        cap   = fifo_en ? 64 : 1;
        do_rd = rd_en && q.size() > 0;
        do_wr = wr_en && (q.size() < cap || do_rd);
        if (wr_en && !do_wr) m_ovr = 1;
        if (do_rd || do_wr || q.size() == 0) m_idle = 0;
        else if (char_tick && m_idle < 4) m_idle++;
        m_arm = mode1 ? act : 0;
        if (do_rd) m_last = q.pop_front();
        if (do_wr) q.push_back(wr_data);
    endtask

    task automatic compare();
        string rq;
        rq = (fifo_en && dma_mode) ? "R9" : (fifo_en ? "R8" : "R10");
        chk(fifo_en ? "R2 level" : "R3 level", level, q.size());
        chk("R2 rd_data", rd_data, m_last);
        chk("R4 overrun", overrun, m_ovr);
        chk("R6 trig_hit", trig_hit, e_trig());
        chk("R7 timeout", timeout, e_to());
        chk(rq, rxrdy_n, e_rdy_n());
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cycles++;
        compare();
        wr_en = 0; rd_en = 0; char_tick = 0;
    endtask

    task automatic put(byte unsigned d);
        wr_en = 1; wr_data = d; step();
    endtask
    task automatic get();
        rd_en = 1; step();
    endtask
    task automatic tick();
        char_tick = 1; step();
    endtask
    task automatic do_reset();
        rst = 1; step(); rst = 0;
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure.
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(); do_reset();
        // R1: reset state
        chk("R1 level", level, 0);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 overrun", overrun, 0);
        chk("R1 rd_data", rd_data, 0);

        // R5: read on empty changes nothing
        get();
        chk("R5 rd_data", rd_data, 0);
        chk("R5 level", level, 0);

        // R2 / R8: short burst in single-transfer discipline
        fifo_en = 1; dma_mode = 0;
        put(8'h11); put(8'h22); put(8'h33);
        get(); chk("R2 first out", rd_data, 8'h11);
        get(); get(); chk("R2 third out", rd_data, 8'h33);
        get(); chk("R5 stale data", rd_data, 8'h33);

        // R2/R4/R6: fill past full while sweeping thresholds
        for (int i = 0; i < 66; i++) begin
            trig_sel = 2'(i % 4);
            put(8'(i + 8'h40));
        end
        chk("R4 overrun set", overrun, 1);
        chk("R2 full level", level, 64);
        rd_en = 1; wr_en = 1; wr_data = 8'hEE; step();   // simultaneous at full
        chk("R2 full rd+wr", level, 64);
        for (int i = 0; i < 64; i++) begin
            trig_sel = 2'(i % 4);
            get();
        end
        chk("R2 last out", rd_data, 8'hEE);
        chk("R4 still set", overrun, 1);

        // R9: burst discipline with threshold 16
        do_reset();
        dma_mode = 1; trig_sel = 2'd1;
        for (int i = 0; i < 16; i++) put(8'(i));
        chk("R9 low at threshold", rxrdy_n, 0);
        for (int i = 0; i < 15; i++) get();
        chk("R9 held below threshold", rxrdy_n, 0);
        get();
        chk("R9 released on empty", rxrdy_n, 1);

        // R7/R9: idle timeout, restart, then drain
        trig_sel = 2'd3;
        put(8'hA1); put(8'hA2);
        tick(); tick(); tick();
        put(8'hA3);                           // restarts the count
        tick(); tick(); tick();
        chk("R7 not yet", timeout, 0);
        tick();
        chk("R7 fired", timeout, 1);
        chk("R9 low on timeout", rxrdy_n, 0);
        get(); get();
        chk("R9 held", rxrdy_n, 0);
        get();
        chk("R9 high on drain", rxrdy_n, 1);
        tick(); tick(); tick(); tick(); tick();
        chk("R7 empty never times out", timeout, 0);

        // R11: mode change flushes
        put(8'h01); put(8'h02); put(8'h03);
        fifo_en = 0; step();
        chk("R11 flushed", level, 0);

        // R3/R10: holding register, burst select ignored
        do_reset();
        fifo_en = 0; dma_mode = 1; trig_sel = 2'd0;
        step();
        put(8'h5A);
        chk("R10 request per character", rxrdy_n, 0);
        chk("R6 no threshold in holding mode", trig_hit, 0);
        put(8'h5B);
        chk("R3 capacity one", level, 1);
        chk("R4 holding overrun", overrun, 1);
        get();
        chk("R3 holding data", rd_data, 8'h5A);
        chk("R10 released", rxrdy_n, 1);
        tick(); tick(); tick(); tick();
        fifo_en = 1; step(); step();
        chk("R11 back to queue", level, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule